// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Gain Updater

This block holds the volume state of a stereo pair of digital audio channels. A host writes a gain code, a zero-cross enable and a mute bit for either channel. The block keeps, per channel, the gain code that is currently in force and a waiting code. It also watches each channel's signed PCM sample stream. A written code goes straight into force when zero-cross gating is off. When gating is on, the code waits until the channel's signal sits near zero, or until a long master-clock timeout runs out. Changing gain at a near-zero point keeps audible clicks and zipper noise out of the output.

A link bit on a left-channel write copies the same gain code into the right channel as well, so one host write sets both sides. The right channel still applies its own gating to the copied code. A level input switches the forced timeout off, and a threshold input sets how close to zero a sample must be. Each channel presents its active 8-bit code, its mute flag and an update-pending flag to the multiplier stage that follows.

Top module: `zcg_stereo_gain`

## Requirements
- R1: After reset, both active gain codes are 0xCF (the 0 dB code), both mutes are 0, both pending flags are 0 and zero-cross gating is off on both channels.
- R2: A gain write with a zero-cross enable of 0 puts the code into force on the clock edge that takes the write. The pending flag of that channel is 0 afterwards.
- R3: A gain write with a zero-cross enable of 1 sets the channel's pending flag and leaves its active code unchanged until a commit condition occurs.
- R4: While a channel is pending, a sample with its valid strobe high and an absolute value at or below the threshold commits the waiting code on that edge. Samples taken while the strobe is low have no effect.
- R5: While a channel is pending, a valid sample whose sign bit differs from that of the previous valid sample on the same channel commits the waiting code on that edge.
- R6: With the timeout enabled (timeout-disable input 0), a pending code commits exactly TIMEOUT_CYC clock cycles after the write that loaded it, even if no sample qualifies.
- R7: With the timeout-disable input at 1, a pending code stays pending for any number of cycles and commits only on a qualifying sample.
- R8: A gain write that arrives while a code is pending replaces the waiting code and restarts the timeout. Only the newest code is ever put into force.
- R9: Each mute bit takes the value of its own channel's write on the edge that takes the write. A write to one channel leaves the other channel's mute unchanged.
- R10: A left write with the link bit at 1 loads its gain code into the right channel as well. The right channel's zero-cross enable and mute are kept, and its own gating decides when the code goes into force.
- R11: Each channel's commit depends only on its own samples. A qualifying sample on the left never commits a code waiting on the right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_left_i | input | 1 | Write strobe for left-channel settings |
| wr_right_i | input | 1 | Write strobe for right-channel settings |
| wr_gain_i | input | GAIN_W | Gain code carried by the write |
| wr_zc_i | input | 1 | Zero-cross enable carried by the write |
| wr_mute_i | input | 1 | Mute carried by the write |
| wr_link_i | input | 1 | On a left write, also load the gain code into the right channel |
| tmo_dis_i | input | 1 | 1 turns off the forced timeout commit |
| zc_thr_i | input | SMP_W | Near-zero magnitude threshold (unsigned) |
| l_vld_i | input | 1 | Left sample valid strobe |
| l_smp_i | input | SMP_W | Left signed PCM sample |
| r_vld_i | input | 1 | Right sample valid strobe |
| r_smp_i | input | SMP_W | Right signed PCM sample |
| gain_l_o | output | GAIN_W | Active left gain code |
| gain_r_o | output | GAIN_W | Active right gain code |
| mute_l_o | output | 1 | Left mute |
| mute_r_o | output | 1 | Right mute |
| pend_l_o | output | 1 | Left code waiting to commit |
| pend_r_o | output | 1 | Right code waiting to commit |

## Verification
Every result comes out of a single register stage. An ungated write, a mute write and a qualifying valid sample all show their effect one edge after the input is presented. A timeout commit shows up exactly TIMEOUT_CYC edges after the loading write, and the pending flag is still high on the edge before. The driver tags each expected snapshot of both channels with the absolute cycle number it is due at. The monitor compares snapshots on the falling edge, half a period after the register updates, so each check hits the exact cycle, including the cycle just before a timeout and the cycle it fires.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
   // number of channels handled by the block and their slots
   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_L   = 0;
   localparam int unsigned CH_R   = 1;

   // per-channel update state
   typedef enum logic {
      UPD_IDLE = 1'b0,
      UPD_WAIT = 1'b1
   } upd_st_e;
endpackage

// File: rtl/zcg_detect.sv
module zcg_detect #(
   parameter int unsigned SMP_W    = 24,
   parameter bit          SIGN_CHG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [SMP_W-1:0] smp_i,
   input  logic        [SMP_W-1:0] thr_i,
   output logic                    hit_o
);
   localparam int unsigned MW = SMP_W + 1;

   if (SMP_W < 2) begin : g_bad_w
      $error("zcg_detect: SMP_W must be at least 2");
   end

   logic signed [MW-1:0] ext;
   logic        [MW-1:0] mag;
   logic                 mag_hit;
   logic                 sgn_hit;

   assign ext     = {smp_i[SMP_W-1], smp_i};
   assign mag     = ext[MW-1] ? (~ext + MW'(1)) : ext;
   assign mag_hit = vld_i && (mag <= {1'b0, thr_i});

   if (SIGN_CHG) begin : g_sign
      logic prev_neg_q;
      logic have_prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_neg_q  <= 1'b0;
            have_prev_q <= 1'b0;
         end else if (vld_i) begin
            prev_neg_q  <= smp_i[SMP_W-1];
            have_prev_q <= 1'b1;
         end
      end
      assign sgn_hit = vld_i && have_prev_q && (prev_neg_q != smp_i[SMP_W-1]);
   end else begin : g_nosign
      assign sgn_hit = 1'b0;
   end

   assign hit_o = mag_hit || sgn_hit;

   // R4
   idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |-> !hit_o);
   // R4
   zero_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && smp_i == '0) |-> hit_o);
endmodule

// File: rtl/zcg_chan.sv
module zcg_chan
   import zcg_pkg::*;
#(
   parameter int unsigned           GAIN_W      = 8,
   parameter int unsigned           TIMEOUT_CYC = 131072,
   parameter logic [GAIN_W-1:0]     RST_GAIN    = 8'hCF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gain_ld_i,
   input  logic [GAIN_W-1:0] gain_i,
   input  logic              ctl_ld_i,
   input  logic              zc_i,
   input  logic              mute_i,
   input  logic              tod_i,
   input  logic              hit_i,
   output logic [GAIN_W-1:0] gain_o,
   output logic              mute_o,
   output logic              pend_o
);
   localparam int unsigned CW   = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [CW-1:0] CLAST = CW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("zcg_chan: TIMEOUT_CYC must be at least 2");
   end
   if (GAIN_W < 1) begin : g_bad_gw
      $error("zcg_chan: GAIN_W must be at least 1");
   end

   upd_st_e           st_q;
   logic [GAIN_W-1:0] act_q;
   logic [GAIN_W-1:0] wait_q;
   logic [CW-1:0]     cnt_q;
   logic              zc_q;
   logic              mute_q;
   logic              zc_eff;
   logic              to_fire;

   // the gating mode that applies to this write is the one it carries
   assign zc_eff  = ctl_ld_i ? zc_i : zc_q;
   assign to_fire = (st_q == UPD_WAIT) && !tod_i && (cnt_q == CLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_q   <= 1'b0;
         mute_q <= 1'b0;
      end else if (ctl_ld_i) begin
         zc_q   <= zc_i;
         mute_q <= mute_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= UPD_IDLE;
         act_q  <= RST_GAIN;
         wait_q <= RST_GAIN;
         cnt_q  <= '0;
      end else if (gain_ld_i) begin
         cnt_q <= '0;
         if (zc_eff) begin
            wait_q <= gain_i;
            st_q   <= UPD_WAIT;
         end else begin
            act_q <= gain_i;
            st_q  <= UPD_IDLE;
         end
      end else if (st_q == UPD_WAIT) begin
         if (hit_i || to_fire) begin
            act_q <= wait_q;
            st_q  <= UPD_IDLE;
            cnt_q <= '0;
         end else if (cnt_q != CLAST) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign gain_o = act_q;
   assign mute_o = mute_q;
   assign pend_o = (st_q == UPD_WAIT);

   // R2
   imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_ld_i && !zc_eff) |=> (gain_o == $past(gain_i)) && !pend_o);
   // R3
   gated_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_ld_i && zc_eff) |=> pend_o && $stable(gain_o));
   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CLAST);
   // R6
   to_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !tod_i && !gain_ld_i && cnt_q == CLAST) |=> !pend_o);
   // R7
   tod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && tod_i && !hit_i && !gain_ld_i) |=> pend_o && $stable(gain_o));
endmodule

// File: rtl/zcg_stereo_gain.sv
module zcg_stereo_gain
   import zcg_pkg::*;
#(
   parameter int unsigned       GAIN_W      = 8,
   parameter int unsigned       SMP_W       = 24,
   parameter int unsigned       TIMEOUT_CYC = 131072,
   parameter logic [GAIN_W-1:0] RST_GAIN    = 8'hCF,
   parameter bit                SIGN_CHG    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_left_i,
   input  logic                    wr_right_i,
   input  logic [GAIN_W-1:0]       wr_gain_i,
   input  logic                    wr_zc_i,
   input  logic                    wr_mute_i,
   input  logic                    wr_link_i,
   input  logic                    tmo_dis_i,
   input  logic [SMP_W-1:0]        zc_thr_i,
   input  logic                    l_vld_i,
   input  logic signed [SMP_W-1:0] l_smp_i,
   input  logic                    r_vld_i,
   input  logic signed [SMP_W-1:0] r_smp_i,
   output logic [GAIN_W-1:0]       gain_l_o,
   output logic [GAIN_W-1:0]       gain_r_o,
   output logic                    mute_l_o,
   output logic                    mute_r_o,
   output logic                    pend_l_o,
   output logic                    pend_r_o
);
   logic                    vld    [NUM_CH];
   logic signed [SMP_W-1:0] smp    [NUM_CH];
   logic                    hit    [NUM_CH];
   logic                    g_ld   [NUM_CH];
   logic                    c_ld   [NUM_CH];
   logic [GAIN_W-1:0]       gain   [NUM_CH];
   logic                    mute   [NUM_CH];
   logic                    pend   [NUM_CH];

   assign vld[CH_L]  = l_vld_i;
   assign vld[CH_R]  = r_vld_i;
   assign smp[CH_L]  = l_smp_i;
   assign smp[CH_R]  = r_smp_i;

   // a linked left write also loads the right gain; the right control bits stay
   assign g_ld[CH_L] = wr_left_i;
   assign c_ld[CH_L] = wr_left_i;
   assign g_ld[CH_R] = wr_right_i || (wr_left_i && wr_link_i);
   assign c_ld[CH_R] = wr_right_i;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zcg_detect #(
         .SMP_W    (SMP_W),
         .SIGN_CHG (SIGN_CHG)
      ) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .vld_i (vld[c]),
         .smp_i (smp[c]),
         .thr_i (zc_thr_i),
         .hit_o (hit[c])
      );

      zcg_chan #(
         .GAIN_W      (GAIN_W),
         .TIMEOUT_CYC (TIMEOUT_CYC),
         .RST_GAIN    (RST_GAIN)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .gain_ld_i (g_ld[c]),
         .gain_i    (wr_gain_i),
         .ctl_ld_i  (c_ld[c]),
         .zc_i      (wr_zc_i),
         .mute_i    (wr_mute_i),
         .tod_i     (tmo_dis_i),
         .hit_i     (hit[c]),
         .gain_o    (gain[c]),
         .mute_o    (mute[c]),
         .pend_o    (pend[c])
      );
   end

   assign gain_l_o = gain[CH_L];
   assign gain_r_o = gain[CH_R];
   assign mute_l_o = mute[CH_L];
   assign mute_r_o = mute[CH_R];
   assign pend_l_o = pend[CH_L];
   assign pend_r_o = pend[CH_R];

   // R9
   mute_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_left_i |=> mute_l_o == $past(wr_mute_i));
   // R9
   mute_right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_left_i && !wr_right_i) |=> $stable(mute_r_o));
   // R10
   link_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_left_i && wr_link_i && !wr_right_i)
         |=> (pend_r_o || gain_r_o == $past(wr_gain_i)));
   // R11
   right_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_r_o && !r_vld_i && tmo_dis_i && !wr_right_i && !wr_left_i)
         |=> pend_r_o && $stable(gain_r_o));
endmodule

// File: tb/zcg_stereo_gain_bench.sv
module zcg_stereo_gain_bench;
   localparam int unsigned GW  = 8;
   localparam int unsigned SW  = 16;
   localparam int unsigned TMO = 40;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 wr_left = 1'b0, wr_right = 1'b0;
   logic [GW-1:0]        wr_gain = '0;
   logic                 wr_zc = 1'b0, wr_mute = 1'b0, wr_link = 1'b0;
   logic                 tmo_dis = 1'b0;
   logic [SW-1:0]        zc_thr = 16'd4;
   logic                 l_vld = 1'b0, r_vld = 1'b0;
   logic signed [SW-1:0] l_smp = '0, r_smp = '0;
   logic [GW-1:0]        gain_l, gain_r;
   logic                 mute_l, mute_r, pend_l, pend_r;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   // model of the expected port state
   logic [GW-1:0] gl = 8'hCF, gr = 8'hCF;
   logic          ml = 1'b0, mr = 1'b0, pl = 1'b0, pr = 1'b0;

   typedef struct {
      int            due;
      int            ch;
      logic [GW-1:0] g;
      logic          m;
      logic          p;
      string         req;
   } item_t;
   item_t q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   zcg_stereo_gain #(
      .GAIN_W      (GW),
      .SMP_W       (SW),
      .TIMEOUT_CYC (TMO)
   ) u_zcg_stereo_gain (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_left_i  (wr_left),
      .wr_right_i (wr_right),
      .wr_gain_i  (wr_gain),
      .wr_zc_i    (wr_zc),
      .wr_mute_i  (wr_mute),
      .wr_link_i  (wr_link),
      .tmo_dis_i  (tmo_dis),
      .zc_thr_i   (zc_thr),
      .l_vld_i    (l_vld),
      .l_smp_i    (l_smp),
      .r_vld_i    (r_vld),
      .r_smp_i    (r_smp),
      .gain_l_o   (gain_l),
      .gain_r_o   (gain_r),
      .mute_l_o   (mute_l),
      .mute_r_o   (mute_r),
      .pend_l_o   (pend_l),
      .pend_r_o   (pend_r)
   );

   // driver side: expected snapshot of both channels, due off edges from now
   task automatic push(input int off, input string req);
      item_t it;
      it.due = cyc + off; it.ch = 0; it.g = gl; it.m = ml; it.p = pl; it.req = req;
      q.push_back(it);
      it.ch = 1; it.g = gr; it.m = mr; it.p = pr;
      q.push_back(it);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_wr(input logic l, input logic r, input logic [GW-1:0] g,
                           input logic zc, input logic m, input logic lk);
      wr_left = l; wr_right = r; wr_gain = g; wr_zc = zc; wr_mute = m; wr_link = lk;
   endtask

   task automatic end_wr();
      wr_left = 1'b0; wr_right = 1'b0; wr_link = 1'b0;
   endtask

   // monitor side: compare due items half a period after the edge
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         logic [GW-1:0] ag;
         logic am, ap;
         it = q.pop_front();
         ag = (it.ch == 0) ? gain_l : gain_r;
         am = (it.ch == 0) ? mute_l : mute_r;
         ap = (it.ch == 0) ? pend_l : pend_r;
         n_chk++;
         if (it.due != cyc || ag !== it.g || am !== it.m || ap !== it.p) begin
            n_bad++;
            $display("FAIL %s ch%0d cyc %0d: gain %h mute %b pend %b, expected gain %h mute %b pend %b (due %0d)",
                     it.req, it.ch, cyc, ag, am, ap, it.g, it.m, it.p, it.due);
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      push(1, "R1");
      tick(1);

      // R2 ungated left write takes effect on the next edge, right untouched
      drive_wr(1, 0, 8'h80, 0, 0, 0); gl = 8'h80;
      push(1, "R2"); tick(1); end_wr();

      // R9 right mute alone
      drive_wr(0, 1, 8'hCF, 0, 1, 0); mr = 1'b1;
      push(1, "R9"); tick(1); end_wr();

      // R3 gated write waits
      drive_wr(1, 0, 8'h40, 1, 0, 0); pl = 1'b1;
      push(1, "R3"); tick(1); end_wr();
      for (int i = 0; i < 3; i++) begin
         l_vld = 1'b1; l_smp = 16'sd1000;
         push(1, "R3"); tick(1);
      end
      // R4 a zero sample without its strobe is ignored
      l_vld = 1'b0; l_smp = 16'sd0;
      push(1, "R4"); tick(1);
      // R4 small valid sample commits
      l_vld = 1'b1; l_smp = 16'sd3; gl = 8'h40; pl = 1'b0;
      push(1, "R4"); tick(1);
      l_vld = 1'b0;

      // R5 sign change commits
      drive_wr(1, 0, 8'h50, 1, 0, 0); pl = 1'b1;
      push(1, "R5"); tick(1); end_wr();
      l_vld = 1'b1; l_smp = 16'sd500;
      push(1, "R5"); tick(1);
      l_smp = -16'sd500; gl = 8'h50; pl = 1'b0;
      push(1, "R5"); tick(1);
      l_vld = 1'b0;

      // R6 timeout commit exactly TMO edges after the write
      drive_wr(1, 0, 8'h60, 1, 0, 0); pl = 1'b1;
      push(1, "R6"); push(TMO, "R6");
      gl = 8'h60; pl = 1'b0;
      push(TMO + 1, "R6");
      tick(1); end_wr(); tick(TMO);

      // R8 rewrite replaces the waiting code and restarts the timeout
      drive_wr(1, 0, 8'h70, 1, 0, 0); pl = 1'b1;
      push(1, "R8"); tick(1); end_wr(); tick(19);
      drive_wr(1, 0, 8'h71, 1, 0, 0);
      push(1, "R8"); push(21, "R8"); push(TMO, "R8");
      gl = 8'h71; pl = 1'b0;
      push(TMO + 1, "R8");
      tick(1); end_wr(); tick(TMO);

      // R7 timeout disabled: stays pending, then a zero sample commits
      tmo_dis = 1'b1;
      drive_wr(1, 0, 8'h33, 1, 0, 0); pl = 1'b1;
      push(1, "R7"); push(TMO + 20, "R7");
      tick(1); end_wr(); tick(TMO + 19);
      l_vld = 1'b1; l_smp = 16'sd0; gl = 8'h33; pl = 1'b0;
      push(1, "R7"); tick(1);
      l_vld = 1'b0;

      // R10 linked left write loads both, right mute kept
      drive_wr(1, 0, 8'h22, 0, 0, 1); gl = 8'h22; gr = 8'h22;
      push(1, "R10"); tick(1); end_wr();

      // right gated write, committed by its own sample
      drive_wr(0, 1, 8'h22, 1, 1, 0); pr = 1'b1;
      push(1, "R3"); tick(1); end_wr();
      r_vld = 1'b1; r_smp = 16'sd0; pr = 1'b0;
      push(1, "R4"); tick(1);
      r_vld = 1'b0;

      // R10 linked write into a gated right channel waits there
      drive_wr(1, 0, 8'h11, 0, 0, 1); gl = 8'h11; pr = 1'b1;
      push(1, "R10"); tick(1); end_wr();
      // R11 left zero sample does not commit the right channel
      l_vld = 1'b1; l_smp = 16'sd0;
      push(1, "R11"); tick(1);
      l_vld = 1'b0;
      r_vld = 1'b1; r_smp = 16'sd1; gr = 8'h11; pr = 1'b0;
      push(1, "R10"); tick(1);
      r_vld = 1'b0;

      // R9 left mute alone
      drive_wr(1, 0, 8'h11, 0, 1, 0); ml = 1'b1;
      push(1, "R9"); tick(1); end_wr();
      tmo_dis = 1'b0;

      tick(2);
      if (q.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL queue: %0d items unchecked, expected 0", q.size());
      end
      finish_run();
   end
endmodule